// File: doc/BRIEF.md
# Dual Parallel I/O Port with Timer Pin Sharing

This block provides two byte-wide general-purpose I/O ports behind a small CPU register window. Each pin of each port has its own direction bit and a latched output value. Each pin drives a tri-state pad through a registered output value and a registered output enable. Pin levels coming back from the pads pass through a two-flop synchroniser before any logic uses them. The synchroniser is the only filtering applied to the inputs.

The pins of port A are also the pins of a four-channel counter/timer. A single mode bit in a configuration register hands port A over to the timer. In that mode the lower half of the port becomes timer trigger inputs, and the synchronised levels of those pins are passed to the timer. The upper half is driven by the timer's zero-count outputs. While the timer owns the pins, the port's own data and direction registers keep their contents but have no effect on the pads. Clearing the mode bit gives the port back with its earlier settings.

Top module: `shared_pin_pio`

## Requirements
- R1: After reset, every output enable of both ports is 0 (all pins inputs), and every register (both data, both direction, configuration) reads 00h.
- R2: Register offsets on `reg_addr` are: 0 port A data, 1 port A direction, 2 port B data, 3 port B direction, 4 configuration. A write at the rising edge with `reg_wr` high updates the addressed register.
- R3: In normal mode, direction bit 1 makes that pin an output: its pad enable is 1 and its pad value equals the data bit. Direction bit 0 makes the pin an input with pad enable 0. This is decided per pin, two clock edges after the write.
- R4: A read of a data register returns the latched data bit for output pins and the synchronised pin level for input pins. `reg_rdata` is registered: it reflects `reg_addr` one edge later.
- R5: A pin level change reaches the read path through exactly two synchroniser flops. With the address held, the read value changes on the third rising edge after the pin changes, and not before.
- R6: Configuration bit 0 selects timer mode. The other bits of the configuration register read back 0. A direction register reads back its stored value in either mode.
- R7: In timer mode, port A output enables are F0h, the upper four pad values follow `tmr_zc` one edge later, and the lower four pad values are 0. `tmr_trig` carries the synchronised levels of port A pins 3..0.
- R8: In timer mode, writes to port A data and direction have no effect on the pads, and a read of port A data returns the synchronised level of all eight pins. The written values take effect when timer mode is cleared.
- R9: Outside timer mode, `tmr_trig` is 0.
- R10: Port B behaves the same in both modes. Offsets 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pa_pin_in | input | 8 | Port A pad input levels |
| pa_pad_out | output | 8 | Port A pad output values |
| pa_pad_oe | output | 8 | Port A pad output enables |
| pb_pin_in | input | 8 | Port B pad input levels |
| pb_pad_out | output | 8 | Port B pad output values |
| pb_pad_oe | output | 8 | Port B pad output enables |
| tmr_zc | input | 4 | Timer zero-count outputs to drive onto port A pins 7..4 |
| tmr_trig | output | 4 | Synchronised port A pins 3..0 for the timer trigger inputs |

## Verification
The bench builds the block with its default parameters: an 8-bit port width, a 4/4 split between trigger and zero-count pins, and a two-stage synchroniser. With this width, random direction, data and pin bytes cover mixed input/output patterns in every bit position within a few hundred trials. The two-stage depth lets the bench check the edge on which an input change first becomes visible. The even split makes the F0h enable pattern and the zero-count path in timer mode directly observable. The same split allows register writes made during timer mode to be checked after the port is given back.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_A_DATA = 3'd0,
    RA_A_DIR  = 3'd1,
    RA_B_DATA = 3'd2,
    RA_B_DIR  = 3'd3,
    RA_CFG    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
      end
      // R5: output equals the input two edges earlier
      a_r5_two_flop: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (q == $past(d, 2)));
    end
  endgenerate
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  input  logic         ovr_en,
  input  logic [W-1:0] ovr_oe,
  input  logic [W-1:0] ovr_out,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] rd_dir
);
  logic [W-1:0] data_q, dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else if (ovr_en) begin
      pad_out <= ovr_out;
      pad_oe  <= ovr_oe;
    end else begin
      pad_out <= data_q;
      pad_oe  <= dir_q;
    end
  end

  assign rd_data = ovr_en ? pin_sync : ((dir_q & data_q) | (~dir_q & pin_sync));
  assign rd_dir  = dir_q;

  // R1: no pin drives when reset is released
  a_r1_oe_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0));
  // R7: override values reach the pads one edge later
  a_r7_override_pads: assert property (@(posedge clk) disable iff (rst)
    ovr_en |=> (pad_oe == $past(ovr_oe)) && (pad_out == $past(ovr_out)));
  // R3: in normal mode the pad enables track the direction register
  a_r3_oe_from_dir: assert property (@(posedge clk) disable iff (rst)
    !ovr_en |=> (pad_oe == $past(rd_dir)));
endmodule

// File: rtl/shared_pin_pio.sv
module shared_pin_pio
  import pio_pkg::*;
#(
  parameter int W      = 8,
  parameter int TRIG_N = 4,
  parameter int SYNC_N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [W-1:0]        reg_wdata,
  output logic [W-1:0]        reg_rdata,
  input  logic [W-1:0]        pa_pin_in,
  output logic [W-1:0]        pa_pad_out,
  output logic [W-1:0]        pa_pad_oe,
  input  logic [W-1:0]        pb_pin_in,
  output logic [W-1:0]        pb_pad_out,
  output logic [W-1:0]        pb_pad_oe,
  input  logic [W-TRIG_N-1:0] tmr_zc,
  output logic [TRIG_N-1:0]   tmr_trig
);
  localparam int ZC_N = W - TRIG_N;

  logic [W-1:0] pa_sync, pb_sync;
  logic [W-1:0] pa_rd, pa_dir, pb_rd, pb_dir;
  logic         tmr_mode;
  logic [W-1:0] a_ovr_oe, a_ovr_out;

  pio_sync #(.W(W), .STAGES(SYNC_N)) u_sync_a (
    .clk(clk), .rst(rst), .d(pa_pin_in), .q(pa_sync));
  pio_sync #(.W(W), .STAGES(SYNC_N)) u_sync_b (
    .clk(clk), .rst(rst), .d(pb_pin_in), .q(pb_sync));

  assign a_ovr_oe  = {{ZC_N{1'b1}}, {TRIG_N{1'b0}}};
  assign a_ovr_out = {tmr_zc, {TRIG_N{1'b0}}};

  pio_port #(.W(W)) u_port_a (
    .clk(clk), .rst(rst),
    .wr_data(reg_wr && reg_addr == RA_A_DATA),
    .wr_dir (reg_wr && reg_addr == RA_A_DIR),
    .wdata(reg_wdata), .pin_sync(pa_sync),
    .ovr_en(tmr_mode), .ovr_oe(a_ovr_oe), .ovr_out(a_ovr_out),
    .pad_out(pa_pad_out), .pad_oe(pa_pad_oe),
    .rd_data(pa_rd), .rd_dir(pa_dir));

  pio_port #(.W(W)) u_port_b (
    .clk(clk), .rst(rst),
    .wr_data(reg_wr && reg_addr == RA_B_DATA),
    .wr_dir (reg_wr && reg_addr == RA_B_DIR),
    .wdata(reg_wdata), .pin_sync(pb_sync),
    .ovr_en(1'b0), .ovr_oe('0), .ovr_out('0),
    .pad_out(pb_pad_out), .pad_oe(pb_pad_oe),
    .rd_data(pb_rd), .rd_dir(pb_dir));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_mode <= 1'b0;
      tmr_trig <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == RA_CFG) tmr_mode <= reg_wdata[0];
      tmr_trig <= tmr_mode ? pa_sync[TRIG_N-1:0] : '0;
      case (reg_addr)
        RA_A_DATA: reg_rdata <= pa_rd;
        RA_A_DIR:  reg_rdata <= pa_dir;
        RA_B_DATA: reg_rdata <= pb_rd;
        RA_B_DIR:  reg_rdata <= pb_dir;
        RA_CFG:    reg_rdata <= {{(W-1){1'b0}}, tmr_mode};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R9: no trigger activity outside timer mode
  a_r9_trig_quiet: assert property (@(posedge clk) disable iff (rst)
    !tmr_mode |=> (tmr_trig == '0));
  // R6: configuration upper bits read as zero
  a_r6_cfg_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_CFG) |=> (reg_rdata[W-1:1] == '0));
  // R10: unmapped offsets read zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > RA_CFG) |=> (reg_rdata == '0));
endmodule

// File: tb/shared_pin_pio_tb.sv
module shared_pin_pio_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pa_pin_in = '0, pa_pad_out, pa_pad_oe;
  logic [7:0] pb_pin_in = '0, pb_pad_out, pb_pad_oe;
  logic [3:0] tmr_zc = '0, tmr_trig;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shared_pin_pio dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pa_pin_in(pa_pin_in), .pa_pad_out(pa_pad_out), .pa_pad_oe(pa_pad_oe),
    .pb_pin_in(pb_pin_in), .pb_pad_out(pb_pad_out), .pb_pad_oe(pb_pad_oe),
    .tmr_zc(tmr_zc), .tmr_trig(tmr_trig));

  function automatic logic [7:0] exp_read(logic [7:0] dir, logic [7:0] dat, logic [7:0] pin);
    return (dir & dat) | (~dir & pin);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, adir, adat, bdir, bdat, pa, pb;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pa_oe", pa_pad_oe, 8'h00);
    chk("R1 pb_oe", pb_pad_oe, 8'h00);
    for (int a = 0; a < 5; a++) begin
      pa_pin_in = 8'h00; pb_pin_in = 8'h00;
      rd(a[2:0], v); chk("R1 reg reset", v, 8'h00);
    end
    // R2/R3 directed: mixed direction on A
    wr(3'd0, 8'hA5); wr(3'd1, 8'h0F); pa_pin_in = 8'h3C; settle();
    chk("R3 pa_oe", pa_pad_oe, 8'h0F);
    chk("R3 pa_out", pa_pad_out, 8'hA5);
    rd(3'd0, v); chk("R4 pa read mix", v, exp_read(8'h0F, 8'hA5, 8'h3C));
    rd(3'd1, v); chk("R2 pa dir read", v, 8'h0F);
    // R5 synchroniser latency
    @(negedge clk); reg_addr = 3'd0; pa_pin_in = 8'h00;
    settle();
    pa_pin_in = 8'hF0;
    @(negedge clk);
    @(negedge clk); chk("R5 not yet visible", reg_rdata, exp_read(8'h0F, 8'hA5, 8'h00));
    @(negedge clk); chk("R5 visible third edge", reg_rdata, exp_read(8'h0F, 8'hA5, 8'hF0));
    // R6 config readback
    wr(3'd4, 8'hFE); rd(3'd4, v); chk("R6 cfg bit0 clear", v, 8'h00);
    // R10 unmapped
    wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd5, v); chk("R10 unmapped read", v, 8'h00);
    rd(3'd0, v); chk("R10 no side effect", v, exp_read(8'h0F, 8'hA5, 8'hF0));
    rd(3'd4, v); chk("R10 cfg untouched", v, 8'h00);
    // Random normal-mode trials: R3, R4, R10 for port B
    for (int t = 0; t < 150; t++) begin
      adir = 8'($urandom); adat = 8'($urandom); bdir = 8'($urandom); bdat = 8'($urandom);
      pa = 8'($urandom); pb = 8'($urandom);
      wr(3'd0, adat); wr(3'd1, adir); wr(3'd2, bdat); wr(3'd3, bdir);
      pa_pin_in = pa; pb_pin_in = pb; settle();
      chk("R3 rand pa_oe", pa_pad_oe, adir);
      chk("R3 rand pa_out", pa_pad_out & adir, adat & adir);
      chk("R3 rand pb_oe", pb_pad_oe, bdir);
      chk("R9 trig idle", {4'h0, tmr_trig}, 8'h00);
      rd(3'd0, v); chk("R4 rand pa read", v, exp_read(adir, adat, pa));
      rd(3'd2, v); chk("R4 rand pb read", v, exp_read(bdir, bdat, pb));
    end
    // Timer mode: R7, R8, R10 (port B unaffected)
    wr(3'd0, 8'h5A); wr(3'd1, 8'hFF); wr(3'd2, 8'hC3); wr(3'd3, 8'h3C);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R6 cfg bit0 set", v, 8'h01);
    for (int t = 0; t < 40; t++) begin
      pa = 8'($urandom); pb = 8'($urandom);
      pa_pin_in = pa; pb_pin_in = pb; tmr_zc = 4'($urandom);
      if (t == 5) begin wr(3'd0, 8'h00); wr(3'd1, 8'h00); end
      settle();
      chk("R7 pa_oe", pa_pad_oe, 8'hF0);
      chk("R7 pa_out", pa_pad_out, {tmr_zc, 4'h0});
      chk("R7 trig", {4'h0, tmr_trig}, {4'h0, pa[3:0]});
      chk("R10 pb_oe mode", pb_pad_oe, 8'h3C);
      rd(3'd0, v); chk("R8 pa read pins", v, pa);
      rd(3'd2, v); chk("R10 pb read mode", v, exp_read(8'h3C, 8'hC3, pb));
    end
    rd(3'd1, v); chk("R6 dir kept in mode", v, 8'h00);
    // R8: written values take effect once mode clears
    wr(3'd0, 8'h69); wr(3'd1, 8'hF0);
    chk("R8 pads unchanged in mode", pa_pad_oe, 8'hF0);
    wr(3'd4, 8'h00); settle();
    chk("R8 restore oe", pa_pad_oe, 8'hF0);
    chk("R8 restore out", pa_pad_out, 8'h69);
    chk("R9 trig cleared", {4'h0, tmr_trig}, 8'h00);
    wr(3'd1, 8'h0F); settle();
    chk("R8 port back", pa_pad_oe, 8'h0F);
    // R1: reset again clears everything
    @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 re-reset oe", pa_pad_oe, 8'h00);
    rd(3'd1, v); chk("R1 re-reset dir", v, 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule